// File: doc/BRIEF.md
# Banked Byte Subtract-with-Borrow and Nibble-Swap Execution Unit

This unit executes two byte instructions of a small 8-bit core. The first subtracts the working register and a pending borrow from a data-memory byte. The second exchanges the two nibbles of a data-memory byte. It holds the working register (W) and a five-flag status register. It reaches a banked data memory through a synchronous read/write port. The operand address comes from a fixed access bank or from a bank select input.

Each machine cycle has four clock phases: decode, operand read, process, write. The unit advances through them without stopping. The instruction word is sampled at the close of the decode phase, so the surrounding core must hold a no-op word whenever it has nothing to run. The memory returns read data one clock after it sees the address. The result goes either to W or back to the addressed byte, as the destination bit selects.

Top module: `subswap_exu`

## Requirements
- R1: During and directly after a synchronous active-high reset, W reads 00h, every status flag reads 0, `phase_o` reads 0 (decode) and `mem_we_o` is low.
- R2: `phase_o` steps through 0 (decode), 1 (read), 2 (process) and 3 (write), then returns to 0, once per clock. `instr_i` is sampled on the clock edge that ends phase 0.
- R3: A word whose bits [15:10] are 010110 subtracts. The result is (operand − W − (1 − C)) mod 256, where C is the carry flag held before the instruction.
- R4: After a subtract, C = 1 exactly when no borrow left bit 7. DC = 1 exactly when no borrow left bit 3.
- R5: After a subtract, N is result bit 7 and Z = 1 when the result is 00h. OV = 1 when the operand and W differ in sign and the result's sign differs from the operand's sign. `status_o` packs the flags as bit 4 N, bit 3 OV, bit 2 Z, bit 1 DC, bit 0 C.
- R6: A word whose bits [15:10] are 001110 produces the operand with bits 3:0 and 7:4 exchanged, and leaves all five status flags unchanged.
- R7: Bit 9 is the destination. When it is 0, W takes the result on the edge that ends phase 3 and memory is not written. When it is 1, `mem_we_o` is high in phase 3 with the result on `mem_wdata_o`, and W is unchanged.
- R8: Bit 8 selects the bank mode. With bit 8 = 0 and address byte f (bits 7:0) below 60h, the address is {0h, f}. With bit 8 = 0 and f at 60h or above, the address is {Fh, f}. With bit 8 = 1, the address is {bsr_i[3:0], f}. The address is held through phases 1 to 3.
- R9: Any word that matches neither pattern changes no W bit, no status flag and no memory byte.
- R10: `mem_we_o` is never high outside phase 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Instruction word, sampled at the end of phase 0 |
| bsr_i | input | 8 | Bank select; the low BANK_W bits are used |
| mem_addr_o | output | 12 | Data memory address (BANK_W + 8) |
| mem_rdata_i | input | 8 | Synchronous read data, valid one clock after the address |
| mem_wdata_o | output | 8 | Write-back result |
| mem_we_o | output | 1 | Memory write enable |
| phase_o | output | 2 | Current phase, 0 to 3 |
| w_o | output | 8 | Working register |
| status_o | output | 5 | {N, OV, Z, DC, C} |

## Verification
The bench builds the unit with its default parameters: four bank bits, an access split at 60h and the top bank as the register region. This reaches every address form: both sides of the access split and a bank chosen through `bsr_i`. A reference model in the bench tracks the phase every clock, along with W, the flags and the memory. It predicts each result from the flag state left by the previous instruction. This covers borrow chaining, zero results, signed overflow, a half-borrow, both destinations and no-op words.

// File: rtl/exu_pkg.sv
package exu_pkg;

    typedef enum logic [1:0] {
        PH_DECODE = 2'd0,
        PH_READ   = 2'd1,
        PH_PROC   = 2'd2,
        PH_WRITE  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SUBB = 2'd1,
        OP_SWAP = 2'd2
    } op_e;

    typedef struct packed {
        logic n;
        logic ov;
        logic z;
        logic dc;
        logic c;
    } flags_t;

    typedef struct packed {
        op_e        op;
        logic       to_mem;
        logic       banked;
        logic [7:0] faddr;
    } dec_t;

    localparam logic [5:0] SUBB_PATTERN = 6'b010110;
    localparam logic [5:0] SWAP_PATTERN = 6'b001110;

    function automatic dec_t decode_word(input logic [15:0] iw);
        dec_t d;
        d.to_mem = iw[9];
        d.banked = iw[8];
        d.faddr  = iw[7:0];
        if (iw[15:10] == SUBB_PATTERN)      d.op = OP_SUBB;
        else if (iw[15:10] == SWAP_PATTERN) d.op = OP_SWAP;
        else                                d.op = OP_NONE;
        return d;
    endfunction

    function automatic logic [7:0] nib_swap(input logic [7:0] v);
        return {v[3:0], v[7:4]};
    endfunction

endpackage

// File: rtl/exu_phase_seq.sv
module exu_phase_seq
    import exu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase_o
);
    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_DECODE;
        else     phase_q <= phase_e'(phase_q + 2'd1);
    end

    assign phase_o = phase_q;

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WRITE) |=> (phase_q == PH_DECODE));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_READ) |=> (phase_q == PH_PROC));

endmodule

// File: rtl/exu_addr_gen.sv
module exu_addr_gen
    import exu_pkg::*;
#(
    parameter int         BANK_W    = 4,
    parameter logic [7:0] ACC_SPLIT = 8'h60,
    localparam int        ADDR_W    = BANK_W + 8,
    localparam logic [BANK_W-1:0] SFR_BANK = {BANK_W{1'b1}}
) (
    input  dec_t              dec_i,
    input  logic [7:0]        bsr_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [BANK_W-1:0] bank;

    always_comb begin
        if (dec_i.banked)                 bank = bsr_i[BANK_W-1:0];
        else if (dec_i.faddr < ACC_SPLIT) bank = '0;
        else                              bank = SFR_BANK;
        addr_o = {bank, dec_i.faddr};
    end

    always_comb begin
        if (!dec_i.banked)
            assert_access_bank_R8: assert (addr_o[ADDR_W-1:8] == '0 ||
                                           addr_o[ADDR_W-1:8] == SFR_BANK);
    end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
(
    input  op_e        op_i,
    input  logic [7:0] opnd_i,
    input  logic [7:0] w_i,
    input  flags_t     flags_i,
    output logic [7:0] result_o,
    output flags_t     flags_o
);
    logic [8:0] full_sum;
    logic [4:0] low_sum;

    always_comb begin
        full_sum = {1'b0, opnd_i} + {1'b0, ~w_i} + {8'd0, flags_i.c};
        low_sum  = {1'b0, opnd_i[3:0]} + {1'b0, ~w_i[3:0]} + {4'd0, flags_i.c};
        flags_o  = flags_i;
        result_o = 8'h00;
        case (op_i)
            OP_SUBB: begin
                result_o   = full_sum[7:0];
                flags_o.c  = full_sum[8];
                flags_o.dc = low_sum[4];
                flags_o.n  = full_sum[7];
                flags_o.z  = (full_sum[7:0] == 8'h00);
                flags_o.ov = (opnd_i[7] ^ w_i[7]) & (full_sum[7] ^ opnd_i[7]);
            end
            OP_SWAP: result_o = nib_swap(opnd_i);
            default: result_o = 8'h00;
        endcase
    end

    always_comb begin
        if (op_i == OP_SUBB)
            assert_carry_borrow_R4: assert (flags_o.c ==
                ({1'b0, opnd_i} >= ({1'b0, w_i} + {8'd0, ~flags_i.c})));
    end

endmodule

// File: rtl/subswap_exu.sv
module subswap_exu
    import exu_pkg::*;
#(
    parameter int         BANK_W    = 4,
    parameter logic [7:0] ACC_SPLIT = 8'h60,
    localparam int        ADDR_W    = BANK_W + 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       instr_i,
    input  logic [7:0]        bsr_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_rdata_i,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_we_o,
    output logic [1:0]        phase_o,
    output logic [7:0]        w_o,
    output logic [4:0]        status_o
);
    phase_e     phase;
    dec_t       ir_q;
    logic [7:0] w_q;
    flags_t     st_q;
    logic [7:0] res_q;
    flags_t     nflags_q;
    logic [7:0] alu_res;
    flags_t     alu_flags;

    exu_phase_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase)
    );

    exu_addr_gen #(
        .BANK_W    (BANK_W),
        .ACC_SPLIT (ACC_SPLIT)
    ) u_addr (
        .dec_i  (ir_q),
        .bsr_i  (bsr_i),
        .addr_o (mem_addr_o)
    );

    exu_alu u_alu (
        .op_i     (ir_q.op),
        .opnd_i   (mem_rdata_i),
        .w_i      (w_q),
        .flags_i  (st_q),
        .result_o (alu_res),
        .flags_o  (alu_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q     <= '0;
            w_q      <= 8'h00;
            st_q     <= '0;
            res_q    <= 8'h00;
            nflags_q <= '0;
        end else begin
            case (phase)
                PH_DECODE: ir_q <= decode_word(instr_i);
                PH_PROC: begin
                    res_q    <= alu_res;
                    nflags_q <= alu_flags;
                end
                PH_WRITE: begin
                    if (ir_q.op != OP_NONE && !ir_q.to_mem) w_q <= res_q;
                    if (ir_q.op == OP_SUBB) st_q <= nflags_q;
                end
                default: ;
            endcase
        end
    end

    assign mem_we_o    = (phase == PH_WRITE) && (ir_q.op != OP_NONE) && ir_q.to_mem;
    assign mem_wdata_o = res_q;
    assign phase_o     = phase;
    assign w_o         = w_q;
    assign status_o    = st_q;

    assert_w_only_q4_R7: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_WRITE) |=> $stable(w_q));

    assert_swap_keeps_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WRITE && ir_q.op == OP_SWAP) |=> $stable(st_q));

    assert_nop_inert_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WRITE && ir_q.op == OP_NONE) |=> ($stable(w_q) && $stable(st_q)));

    assert_mem_dest_keeps_w_R7: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |=> $stable(w_q));

endmodule

// File: tb/subswap_exu_bench.sv
module subswap_exu_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr_i = 16'h0000;
    logic [7:0]  bsr_i = 8'h00;
    logic [11:0] mem_addr_o;
    logic [7:0]  mem_rdata_i;
    logic [7:0]  mem_wdata_o;
    logic        mem_we_o;
    logic [1:0]  phase_o;
    logic [7:0]  w_o;
    logic [4:0]  status_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0]  mem [0:4095];
    logic        poke_en = 1'b0;
    logic [11:0] poke_a = '0;
    logic [7:0]  poke_d = '0;

    int          ph_m = 0;
    logic [7:0]  w_m  = 8'h00;
    logic [4:0]  st_m = 5'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    subswap_exu u_subswap_exu (
        .clk (clk), .rst (rst), .instr_i (instr_i), .bsr_i (bsr_i),
        .mem_addr_o (mem_addr_o), .mem_rdata_i (mem_rdata_i),
        .mem_wdata_o (mem_wdata_o), .mem_we_o (mem_we_o),
        .phase_o (phase_o), .w_o (w_o), .status_o (status_o)
    );

    always @(posedge clk) begin
        if (poke_en) mem[poke_a] <= poke_d;
        else if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
        mem_rdata_i <= mem[mem_addr_o];
    end

    always @(posedge clk) ph_m <= rst ? 0 : (ph_m + 1) % 4;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(phase_o == ph_m[1:0], "R2 phase", phase_o, ph_m);
            if (ph_m != 3) chk(mem_we_o == 1'b0, "R10 write outside phase 3", mem_we_o, 0);
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        chk(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic poke(input logic [11:0] a, input logic [7:0] d);
        poke_en = 1'b1; poke_a = a; poke_d = d;
        @(negedge clk);
        poke_en = 1'b0;
        while (phase_o != 2'd0) @(negedge clk);
    endtask

    task automatic run(input logic [15:0] iw, input logic [7:0] bsr);
        logic [5:0]  pat;
        logic        d, a;
        logic [7:0]  f, opnd, res;
        logic [11:0] addr;
        int          brw, diff, ldiff;
        logic [4:0]  st_n;
        bit          active;
        pat = iw[15:10]; d = iw[9]; a = iw[8]; f = iw[7:0];
        if (a)              addr = {bsr[3:0], f};
        else if (f < 8'h60) addr = {4'h0, f};
        else                addr = {4'hF, f};
        opnd = mem[addr];
        st_n = st_m; res = 8'h00; active = 1'b0;
        if (pat == 6'b010110) begin
            active = 1'b1;
            brw   = st_m[0] ? 0 : 1;
            diff  = int'(opnd) - int'(w_m) - brw;
            ldiff = int'(opnd[3:0]) - int'(w_m[3:0]) - brw;
            res   = diff[7:0];
            st_n[0] = (diff >= 0);
            st_n[1] = (ldiff >= 0);
            st_n[2] = (res == 8'h00);
            st_n[3] = (opnd[7] != w_m[7]) && (res[7] != opnd[7]);
            st_n[4] = res[7];
        end else if (pat == 6'b001110) begin
            active = 1'b1;
            res = {opnd[3:0], opnd[7:4]};
        end
        instr_i = iw; bsr_i = bsr;
        @(negedge clk);
        instr_i = 16'h0000;
        chk(mem_addr_o == addr, "R8 address", mem_addr_o, addr);
        @(negedge clk);
        @(negedge clk);
        chk(mem_we_o == (active && d), "R7 write enable", mem_we_o, active && d);
        if (active && d) chk(mem_wdata_o == res, "R7 write data", mem_wdata_o, res);
        @(negedge clk);
        if (active && !d) w_m = res;
        st_m = st_n;
        chk(w_o == w_m, "R3/R6/R7/R9 W", w_o, w_m);
        chk(status_o == st_m, "R4/R5/R6/R9 status", status_o, st_m);
        if (active && d) chk(mem[addr] == res, "R7 memory", mem[addr], res);
        else             chk(mem[addr] == opnd, "R9 memory kept", mem[addr], opnd);
    endtask

    task automatic set_w(input logic [7:0] v);
        poke(12'h020, {v[3:0], v[7:4]});
        run(16'h3820, 8'h00);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(w_o == 8'h00, "R1 W reset", w_o, 0);
        chk(status_o == 5'h00, "R1 status reset", status_o, 0);
        chk(phase_o == 2'd0, "R1 phase reset", phase_o, 0);
        chk(mem_we_o == 1'b0, "R1 write reset", mem_we_o, 0);
        // Subtract into W with C=0: 05h - 01h - 1, leaves C set (R3, R4)
        poke(12'h010, 8'h05); set_w(8'h01); run(16'h5810, 8'h00);
        // 19h - 0Dh, C=1, stored back to memory (R3, R7)
        set_w(8'h0D); poke(12'h011, 8'h19); run(16'h5A11, 8'h00);
        // 03h - 0Eh gives F5h, N set, C cleared (R5)
        set_w(8'h0E); poke(12'h012, 8'h03); run(16'h5A12, 8'h00);
        // 1Bh - 1Ah with C=0 gives zero, Z and C set (R4, R5)
        set_w(8'h1A); poke(12'h013, 8'h1B); run(16'h5813, 8'h00);
        // Signed overflow 80h - 01h (R5)
        set_w(8'h01); poke(12'h014, 8'h80); run(16'h5814, 8'h00);
        // Half borrow 10h - 01h (R4)
        set_w(8'h01); poke(12'h015, 8'h10); run(16'h5815, 8'h00);
        // Swap 53h to memory, flags kept (R6)
        poke(12'h016, 8'h53); run(16'h3A16, 8'h00);
        // Banked access through bsr (R8)
        poke(12'h5A7, 8'hC4); run(16'h3BA7, 8'h05);
        set_w(8'h22); poke(12'h5A8, 8'h40); run(16'h5BA8, 8'h25);
        // Access bank, register region and split boundary (R8)
        poke(12'hF70, 8'h9E); run(16'h3A70, 8'h03);
        poke(12'h05F, 8'h12); run(16'h3A5F, 8'h03);
        poke(12'hF60, 8'h21); run(16'h5A60, 8'h07);
        // Unrecognised words (R9)
        poke(12'h030, 8'h77); run(16'h5C30, 8'h00);
        run(16'h3E30, 8'h00);
        run(16'hFFFF, 8'h0F);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule